// File: doc/BRIEF.md
# Memory Request Coalescing Unit

This block sits between a group of 16 load lanes and the memory port. It accepts one request group at a time; each lane brings a valid bit and a byte address, and every lane reads one 4-byte word. The block folds the group into as few memory transactions as the selected merge rule permits. It then hands the transactions out one per handshake. Each transaction names a 128-byte segment and carries a mask of the lanes it serves.

Two merge rules are available, chosen per group. The strict rule only merges a group whose active lanes sit in their natural slots of one aligned segment. Any other pattern falls back to one transaction per lane. The relaxed rule serves every active lane of a segment with a single transaction, whatever the lane order, and issues the segments from the lowest address upward. Lanes with a misaligned word address are reported and dropped.

Top module: `req_coalescer`

## Requirements
- R1: After synchronous reset the block is idle: `in_ready` is 1, `out_valid` is 0, and `grp_done` and `addr_err` are 0.
- R2: With `in_relaxed`=0 (strict rule), a group in which every active lane k has address S*128 + 4*k for one segment number S is issued as exactly one transaction with `out_seg`=S and `out_mask` equal to the active lanes.
- R3: Under the strict rule, any other pattern is issued as one transaction per active lane, in ascending lane order, each with `out_mask` = 1<<k and `out_seg` = that lane's address bits [31:7]. This includes a rotation inside one segment and a sequential run whose base is not 128-byte aligned.
- R4: With `in_relaxed`=1 (relaxed rule), all active lanes whose addresses share bits [31:7] are served by one transaction whose `out_mask` has bit k set for each such lane k, regardless of lane order.
- R5: Under the relaxed rule, transactions of one group are issued in strictly increasing `out_seg` order, so a group spread over two segments gives exactly two transactions, lower segment first.
- R6: Lanes with `in_lane_vld` bit low never appear in any `out_mask`; a group with no active lanes produces no transaction.
- R7: Under the strict rule, a group with inactive lanes still merges into one transaction when every active lane keeps the S*128 + 4*k relation.
- R8: An active lane whose address bits [1:0] are not 00 is dropped from all transactions, and `addr_err` pulses for one cycle, the cycle after the group is accepted.
- R9: A transaction's `out_seg` and `out_mask` hold steady while `out_valid` is 1 and `out_ready` is 0, and `in_ready` stays 0 until the last transaction of the group has been taken.
- R10: `grp_done` pulses for one cycle in the cycle after the last transaction is taken, or in the cycle after acceptance of a group with nothing to issue.
- R11: Asserting `rst` during a group discards its pending transactions and returns the block to the idle state of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A request group is offered |
| in_ready | output | 1 | Block can take a new group |
| in_relaxed | input | 1 | Merge rule: 0 strict, 1 relaxed |
| in_lane_vld | input | LANES | Per-lane active bit, bit k for lane k |
| in_addr | input | LANES*ADDR_W | Lane byte addresses, lane k at bits [k*ADDR_W +: ADDR_W] |
| out_valid | output | 1 | A transaction is offered |
| out_ready | input | 1 | Memory side takes the transaction |
| out_seg | output | ADDR_W-7 | Segment number (address bits [ADDR_W-1:7]) |
| out_mask | output | LANES | Lanes served by the transaction |
| grp_done | output | 1 | One-cycle pulse at the end of a group |
| addr_err | output | 1 | One-cycle pulse: a lane of the accepted group was misaligned |

## Verification
The bench builds the block with its default parameters, 16 lanes and 32-bit addresses. The full 16-bit lane mask is then reachable: full merges, sixteen-way fallbacks and a sixteen-segment spread. Segment numbers near the top of the 32-bit space check that the high address bits reach `out_seg` intact. Throttling `out_ready` on alternate cycles puts the hold and ordering rules under stall.

// File: rtl/coal_pkg.sv
package coal_pkg;

  // byte address bits that select a word inside a 128-byte segment
  localparam int SEG_SHIFT  = 7;
  localparam int WORD_SHIFT = 2;

  typedef enum logic {
    RULE_STRICT  = 1'b0,
    RULE_RELAXED = 1'b1
  } merge_rule_e;

  // offset inside its segment that lane k must use for a strict merge
  function automatic logic [SEG_SHIFT-1:0] slot_offset(input int lane);
    return SEG_SHIFT'(lane << WORD_SHIFT);
  endfunction

  // a word access must have its low address bits clear
  function automatic logic word_misaligned(input logic [WORD_SHIFT-1:0] low_bits);
    return low_bits != '0;
  endfunction

endpackage

// File: rtl/coal_strict_check.sv
module coal_strict_check #(
  parameter int LANES  = 16,
  parameter int ADDR_W = 32
) (
  input  logic [LANES*ADDR_W-1:0] addr_flat,
  input  logic [LANES-1:0]        use_mask,
  output logic                    all_in_slot
);
  import coal_pkg::*;

  localparam int SEG_W = ADDR_W - SEG_SHIFT;

  logic [SEG_W-1:0] ref_seg;
  logic             ref_found;
  logic [LANES-1:0] lane_ok;

  // segment of the lowest active lane is the candidate segment
  always_comb begin
    ref_seg   = '0;
    ref_found = 1'b0;
    for (int k = 0; k < LANES; k++) begin
      if (use_mask[k] && !ref_found) begin
        ref_seg   = addr_flat[k*ADDR_W+SEG_SHIFT +: SEG_W];
        ref_found = 1'b1;
      end
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_slot
    localparam logic [SEG_SHIFT-1:0] SLOT = slot_offset(k);
    logic [SEG_W-1:0]     lane_seg;
    logic [SEG_SHIFT-1:0] lane_off;
    assign lane_seg   = addr_flat[k*ADDR_W+SEG_SHIFT +: SEG_W];
    assign lane_off   = addr_flat[k*ADDR_W +: SEG_SHIFT];
    assign lane_ok[k] = !use_mask[k] || ((lane_seg == ref_seg) && (lane_off == SLOT));
  end

  assign all_in_slot = &lane_ok;

endmodule

// File: rtl/coal_seg_pick.sv
module coal_seg_pick #(
  parameter int LANES = 16,
  parameter int SEG_W = 25
) (
  input  logic [LANES*SEG_W-1:0] seg_flat,
  input  logic [LANES-1:0]       pend,
  output logic [SEG_W-1:0]       min_seg,
  output logic [LANES-1:0]       seg_mask
);
  logic found;

  // lowest segment number among the lanes still pending
  always_comb begin
    min_seg = '0;
    found   = 1'b0;
    for (int k = 0; k < LANES; k++) begin
      if (pend[k] && (!found || (seg_flat[k*SEG_W +: SEG_W] < min_seg))) begin
        min_seg = seg_flat[k*SEG_W +: SEG_W];
        found   = 1'b1;
      end
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_match
    assign seg_mask[k] = pend[k] && (seg_flat[k*SEG_W +: SEG_W] == min_seg);
  end

endmodule

// File: rtl/coal_lane_pick.sv
module coal_lane_pick #(
  parameter int LANES  = 16,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic [LANES-1:0] pend,
  output logic [LANES-1:0] low_onehot,
  output logic [IDX_W-1:0] low_idx
);
  // lowest pending lane wins
  always_comb begin
    low_idx = '0;
    for (int k = LANES - 1; k >= 0; k--) begin
      if (pend[k]) low_idx = IDX_W'(k);
    end
  end

  assign low_onehot = pend & (~pend + LANES'(1));

endmodule

// File: rtl/req_coalescer.sv
module req_coalescer #(
  parameter int LANES  = 16,
  parameter int ADDR_W = 32,
  localparam int SEG_W = ADDR_W - coal_pkg::SEG_SHIFT,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic                    in_relaxed,
  input  logic [LANES-1:0]        in_lane_vld,
  input  logic [LANES*ADDR_W-1:0] in_addr,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [SEG_W-1:0]        out_seg,
  output logic [LANES-1:0]        out_mask,
  output logic                    grp_done,
  output logic                    addr_err
);
  import coal_pkg::*;

  // lane offsets of a strict merge must fit inside one segment
  if (LANES * 4 > 128) begin : g_bad_lanes
    initial $error("LANES too large for one segment");
  end

  // ---------------- input side ----------------
  logic [LANES-1:0]       lane_bad;
  logic [LANES-1:0]       lane_use;
  logic [LANES*SEG_W-1:0] in_seg_flat;
  logic                   strict_fit;
  logic                   accept;

  for (genvar k = 0; k < LANES; k++) begin : g_lane_in
    assign lane_bad[k] = in_lane_vld[k] && word_misaligned(in_addr[k*ADDR_W +: WORD_SHIFT]);
    assign in_seg_flat[k*SEG_W +: SEG_W] = in_addr[k*ADDR_W+SEG_SHIFT +: SEG_W];
  end
  assign lane_use = in_lane_vld & ~lane_bad;

  coal_strict_check #(.LANES(LANES), .ADDR_W(ADDR_W)) u_strict (
    .addr_flat   (in_addr),
    .use_mask    (lane_use),
    .all_in_slot (strict_fit)
  );

  // ---------------- group state ----------------
  logic                   busy_q;
  logic [LANES-1:0]       pend_q;
  merge_rule_e            rule_q;
  logic                   strict_q;
  logic                   done_q;
  logic                   err_q;
  logic [LANES*SEG_W-1:0] seg_q;

  assign in_ready = !busy_q;
  assign accept   = in_valid && in_ready;

  // ---------------- transaction select ----------------
  logic [SEG_W-1:0] rel_seg;
  logic [LANES-1:0] rel_mask;
  logic [LANES-1:0] one_mask;
  logic [IDX_W-1:0] one_idx;
  logic [SEG_W-1:0] one_seg;
  logic             take;
  logic [LANES-1:0] pend_next;
  logic             last_take;

  coal_seg_pick #(.LANES(LANES), .SEG_W(SEG_W)) u_seg_pick (
    .seg_flat (seg_q),
    .pend     (pend_q),
    .min_seg  (rel_seg),
    .seg_mask (rel_mask)
  );

  coal_lane_pick #(.LANES(LANES)) u_lane_pick (
    .pend       (pend_q),
    .low_onehot (one_mask),
    .low_idx    (one_idx)
  );

  assign one_seg = seg_q[one_idx*SEG_W +: SEG_W];

  always_comb begin
    if (rule_q == RULE_RELAXED) begin
      out_seg  = rel_seg;
      out_mask = rel_mask;
    end else if (strict_q) begin
      out_seg  = one_seg;
      out_mask = pend_q;
    end else begin
      out_seg  = one_seg;
      out_mask = one_mask;
    end
  end

  assign out_valid = busy_q;
  assign take      = out_valid && out_ready;
  assign pend_next = pend_q & ~out_mask;
  assign last_take = take && (pend_next == '0);

  // ---------------- sequencing ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      pend_q   <= '0;
      rule_q   <= RULE_STRICT;
      strict_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (accept) begin
        pend_q   <= lane_use;
        rule_q   <= merge_rule_e'(in_relaxed);
        strict_q <= strict_fit;
        err_q    <= |lane_bad;
        if (lane_use == '0) done_q <= 1'b1;
        else                busy_q <= 1'b1;
      end else if (take) begin
        pend_q <= pend_next;
        if (last_take) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  // segment numbers are data only; no reset needed
  always_ff @(posedge clk) begin
    if (accept) seg_q <= in_seg_flat;
  end

  assign grp_done = done_q;
  assign addr_err = err_q;

endmodule

// File: rtl/coal_checker.sv
module coal_checker #(
  parameter int LANES = 16,
  parameter int SEG_W = 25
) (
  input logic             clk,
  input logic             rst,
  input logic             in_ready,
  input logic             accept,
  input logic             out_valid,
  input logic             out_ready,
  input logic [SEG_W-1:0] out_seg,
  input logic [LANES-1:0] out_mask,
  input logic [LANES-1:0] pend_q,
  input logic             relaxed_q,
  input logic             strict_q,
  input logic             grp_done,
  input logic             addr_err
);
  logic             have_prev;
  logic [SEG_W-1:0] prev_seg;

  always_ff @(posedge clk) begin
    if (rst || accept) begin
      have_prev <= 1'b0;
      prev_seg  <= '0;
    end else if (out_valid && out_ready) begin
      have_prev <= 1'b1;
      prev_seg  <= out_seg;
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_seg) && $stable(out_mask));

  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  assert_mask_pending_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_mask != '0) && ((out_mask & ~pend_q) == '0));

  assert_fallback_single_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid && !relaxed_q && !strict_q |-> $onehot(out_mask));

  assert_seg_rising_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid && relaxed_q && have_prev |-> out_seg > prev_seg);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
    grp_done |-> !out_valid);

  assert_err_timing_R8: assert property (@(posedge clk) disable iff (rst)
    addr_err |-> $past(accept));

endmodule

bind req_coalescer coal_checker #(.LANES(LANES), .SEG_W(SEG_W)) u_coal_chk (
  .clk       (clk),
  .rst       (rst),
  .in_ready  (in_ready),
  .accept    (accept),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_seg   (out_seg),
  .out_mask  (out_mask),
  .pend_q    (pend_q),
  .relaxed_q (rule_q == coal_pkg::RULE_RELAXED),
  .strict_q  (strict_q),
  .grp_done  (grp_done),
  .addr_err  (addr_err)
);

// File: tb/req_coalescer_bench.sv
module req_coalescer_bench;
  localparam int LANES  = 16;
  localparam int ADDR_W = 32;
  localparam int SEG_W  = ADDR_W - 7;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic                    in_valid = 1'b0;
  logic                    in_ready;
  logic                    in_relaxed = 1'b0;
  logic [LANES-1:0]        in_lane_vld = '0;
  logic [LANES*ADDR_W-1:0] in_addr;
  logic                    out_valid;
  logic                    out_ready = 1'b0;
  logic [SEG_W-1:0]        out_seg;
  logic [LANES-1:0]        out_mask;
  logic                    grp_done;
  logic                    addr_err;

  logic [31:0] a [LANES];

  always_comb begin
    for (int k = 0; k < LANES; k++) in_addr[k*ADDR_W +: ADDR_W] = a[k];
  end

  always #2 clk = ~clk;

  req_coalescer #(.LANES(LANES), .ADDR_W(ADDR_W)) u_req_coalescer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_relaxed(in_relaxed), .in_lane_vld(in_lane_vld), .in_addr(in_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_seg(out_seg),
    .out_mask(out_mask), .grp_done(grp_done), .addr_err(addr_err)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected transaction list, computed from the requirements
  logic [SEG_W-1:0] e_seg  [32];
  logic [15:0]      e_mask [32];
  int               e_n;
  logic             e_err;

  task automatic model(input bit relaxed, input logic [15:0] vld);
    logic [15:0] use_m, rem, m;
    logic [24:0] ref_s, mn;
    bit ok, found;
    use_m = '0; e_err = 1'b0; e_n = 0;
    for (int k = 0; k < 16; k++) begin
      if (vld[k] && a[k][1:0] != 2'b00) e_err = 1'b1;
      else if (vld[k]) use_m[k] = 1'b1;
    end
    if (!relaxed) begin
      ok = 1; found = 0; ref_s = '0;
      for (int k = 0; k < 16; k++) if (use_m[k]) begin
        if (!found) begin ref_s = a[k][31:7]; found = 1; end
        if (a[k][31:7] != ref_s || a[k][6:0] != 7'(4*k)) ok = 0;
      end
      if (use_m == 0) e_n = 0;
      else if (ok) begin e_seg[0] = ref_s; e_mask[0] = use_m; e_n = 1; end
      else for (int k = 0; k < 16; k++) if (use_m[k]) begin
        e_seg[e_n] = a[k][31:7]; e_mask[e_n] = 16'(1 << k); e_n++;
      end
    end else begin
      rem = use_m;
      while (rem != 0) begin
        mn = '1;
        for (int k = 0; k < 16; k++) if (rem[k] && a[k][31:7] <= mn) mn = a[k][31:7];
        m = '0;
        for (int k = 0; k < 16; k++) if (rem[k] && a[k][31:7] == mn) m[k] = 1'b1;
        e_seg[e_n] = mn; e_mask[e_n] = m; e_n++;
        rem &= ~m;
      end
    end
  endtask

  // offers one group, drains it, compares with the model
  task automatic run_group(input string tag, input bit relaxed, input logic [15:0] vld,
                           input bit stall);
    logic [SEG_W-1:0] g_seg  [32];
    logic [15:0]      g_mask [32];
    int got, cyc;
    bit done_seen, err_seen, overlap;
    model(relaxed, vld);
    @(negedge clk);
    in_valid = 1'b1; in_relaxed = relaxed; in_lane_vld = vld;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    got = 0; cyc = 0; done_seen = 0; overlap = 0;
    err_seen = addr_err;
    while (!done_seen && cyc < 200) begin
      if (grp_done) done_seen = 1;
      else begin
        if (out_valid && in_ready) overlap = 1;
        out_ready = stall ? cyc[0] : 1'b1;
        if (out_valid && out_ready && got < 32) begin
          g_seg[got] = out_seg; g_mask[got] = out_mask; got++;
        end
        @(posedge clk);
        @(negedge clk);
        out_ready = 1'b0;
        if (addr_err) err_seen = 1;
        cyc++;
      end
    end
    chk({tag, " R10 done"}, 64'(done_seen), 64'd1);
    chk({tag, " R8 err"}, 64'(err_seen), 64'(e_err));
    chk({tag, " R9 ready low while busy"}, 64'(overlap), 64'd0);
    chk({tag, " count"}, 64'(got), 64'(e_n));
    for (int i = 0; i < e_n && i < got; i++) begin
      chk({tag, " seg"}, 64'(g_seg[i]), 64'(e_seg[i]));
      chk({tag, " mask"}, 64'(g_mask[i]), 64'(e_mask[i]));
    end
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    chk("R1 in_ready", 64'(in_ready), 64'd1);
    chk("R1 out_valid", 64'(out_valid), 64'd0);
    chk("R1 grp_done", 64'(grp_done), 64'd0);
    chk("R1 addr_err", 64'(addr_err), 64'd0);
  endtask

  task automatic t_strict_merge();
    for (int k = 0; k < 16; k++) a[k] = 32'd128 + 32'(4*k);
    run_group("R2 strict aligned", 0, 16'hFFFF, 0);
    for (int k = 0; k < 16; k++) a[k] = 32'hFFFF_FF80 + 32'(4*k);
    run_group("R2 strict top segment", 0, 16'hFFFF, 1);
  endtask

  task automatic t_strict_fallback();
    a[0] = 32'd192;
    for (int k = 1; k < 16; k++) a[k] = 32'd128 + 32'(4*k);
    run_group("R3 strict rotation", 0, 16'hFFFF, 1);
    for (int k = 0; k < 16; k++) a[k] = 32'h140 + 32'(4*k);
    run_group("R3 strict unaligned base", 0, 16'hFFFF, 0);
  endtask

  task automatic t_relaxed();
    a[0] = 32'd192;
    for (int k = 1; k < 16; k++) a[k] = 32'd128 + 32'(4*k);
    run_group("R4 relaxed rotation", 1, 16'hFFFF, 0);
    for (int k = 0; k < 16; k++) a[k] = k[0] ? 32'h0F80 + 32'(4*k) : 32'h1000 + 32'(4*k);
    run_group("R5 relaxed two segments", 1, 16'hFFFF, 1);
    for (int k = 0; k < 16; k++) a[k] = 32'((15 - k) * 128 + 8);
    run_group("R5 relaxed sixteen segments", 1, 16'hFFFF, 1);
  endtask

  task automatic t_inactive();
    for (int k = 0; k < 16; k++) a[k] = k[2] ? 32'h9999_0003 : 32'h200 + 32'(4*k);
    run_group("R7 strict partial merge", 0, 16'h0F0F, 0);
    run_group("R6 relaxed inactive garbage", 1, 16'h0F0F, 0);
    run_group("R6 empty group", 1, 16'h0000, 0);
  endtask

  task automatic t_misaligned();
    for (int k = 0; k < 16; k++) a[k] = 32'h300 + 32'(4*k);
    a[5] = 32'h300 + 32'd21;
    run_group("R8 strict misaligned lane", 0, 16'hFFFF, 0);
    for (int k = 0; k < 16; k++) a[k] = 32'hFFFF_FF80 + 32'(4*(15 - k));
    a[9] = 32'h0000_0402;
    run_group("R8 relaxed misaligned lane", 1, 16'hFFFF, 0);
  endtask

  task automatic t_mid_reset();
    a[0] = 32'd192;
    for (int k = 1; k < 16; k++) a[k] = 32'd128 + 32'(4*k);
    @(negedge clk);
    in_valid = 1'b1; in_relaxed = 1'b0; in_lane_vld = 16'hFFFF;
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    out_ready = 1'b0;
    chk("R11 busy before reset", 64'(out_valid), 64'd1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R11 out_valid cleared", 64'(out_valid), 64'd0);
    chk("R11 in_ready restored", 64'(in_ready), 64'd1);
    chk("R11 no done", 64'(grp_done), 64'd0);
    @(negedge clk);
    chk("R11 still idle", 64'(out_valid), 64'd0);
    for (int k = 0; k < 16; k++) a[k] = 32'h400 + 32'(4*k);
    run_group("R11 group after reset", 0, 16'hFFFF, 0);
  endtask

  bit finished = 0;

  initial begin
    for (int k = 0; k < LANES; k++) a[k] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_strict_merge();
    t_strict_fallback();
    t_relaxed();
    t_inactive();
    t_misaligned();
    t_mid_reset();
    finished = 1;
  end

  initial begin
    for (int c = 0; c < 20000 && !finished; c++) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule